// File: doc/BRIEF.md
# Step Attenuator Control Front End

This block turns the control pins of a six-cell step attenuator into the registered attenuation word that drives the switched cells. Bit i of the word switches in a cell of 0.5·2^i dB. A 1 inserts the cell and a 0 bypasses it, so the word read as an unsigned number is the attenuation in half-decibel units. A mode input selects the control source. In serial mode, a three-wire bus (data, shift clock, latch enable) fills a shift register, and a latch-enable rising edge moves that register into the active word. In parallel mode, the six pins are captured when latch enable rises, and they pass straight through while latch enable stays high.

The three bus lines arrive without a fixed relation to the system clock. Each passes through a two-flop synchroniser, and edges are found on the synchronised copies. The mode input and the parallel pins are treated as quasi-static and are used directly. A synchronous active-low reset loads both the active word and the shift register from the parallel pins, so the pins set the power-up state in every mode. A one-cycle strobe marks every cycle in which the active word takes a new value.

Top module: `step_atten_ctrl`

## Requirements
- R1: attenWord bit i inserts a cell of 0.5·2^i dB when 1 (bit 5 is 16 dB, bit 0 is 0.5 dB), so the unsigned value of attenWord equals the attenuation in 0.5 dB units.
- R2: modeSerial high selects serial control and modeSerial low selects parallel control. In parallel mode, shift clocks do not alter the shift register, and a latch rise loads the pins rather than the shift register.
- R3: In serial mode, bits are shifted in most significant first: the first of six shift-clock rising edges supplies bit 5 and the sixth supplies bit 0.
- R4: While latch enable is high, shift-clock edges are ignored and the shift register keeps its value.
- R5: In serial mode, a latch-enable rising edge copies the shift register into attenWord, and attenWord does not change between latch rises.
- R6: In parallel mode with latch enable high, attenWord takes parWord on the first rising clock edge after the pins change.
- R7: In parallel mode with latch enable low, changes on parWord have no effect, and a latch-enable rising edge loads the parWord value present at that time.
- R8: While rstN is low at a rising clock edge, attenWord and the shift register load parWord in both modes, and updateStb is 0.
- R9: If latch enable rises after more or fewer than six shift clocks, the six most recently shifted bits are transferred. With fewer clocks, older register bits fill the upper positions.
- R10: updateStb is high for exactly the cycles in which attenWord differs from its value in the previous cycle. Loading an unchanged value gives no strobe.
- R11: A latch-enable rise driven between clock edges changes attenWord, with updateStb high, on the third rising clock edge after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial bus |
| rstN | input | 1 | Synchronous active-low reset; loads defaults from parWord |
| modeSerial | input | 1 | 1 = serial control, 0 = parallel control |
| serClk | input | 1 | Serial shift clock (asynchronous) |
| serData | input | 1 | Serial data, most significant bit first (asynchronous) |
| latchEn | input | 1 | Latch enable: transfers on rise, inhibits shifting when high (asynchronous) |
| parWord | input | 6 | Parallel attenuation pins |
| attenWord | output | 6 | Active attenuation word driving the cells |
| updateStb | output | 1 | One-cycle pulse when attenWord changes |

## Verification
The shift register is hidden, so an error in it shows only at the next latch rise. The bench therefore follows each shift sequence with a transfer, and it checks the exact cycle in which attenWord and updateStb move. A wrong shift order, a shift that slips through the clock inhibit, or a stray shift in parallel mode shows up as a wrong attenWord three cycles after the latch rise. A wrong capture path in parallel mode shows within one cycle when latch enable is high. When latch enable is low, it shows as attenWord moving without a latch rise.

// File: rtl/atten_pkg.sv
package atten_pkg;

  localparam int ATTEN_W = 6;

  // strobes from the control decoder into the datapath
  typedef struct packed {
    logic shiftEn;    // shift one serial bit in
    logic loadShift;  // transfer shift register into the active word
    logic loadPar;    // load the parallel pins into the active word
  } ctrlStb_t;

endpackage

// File: rtl/atten_sync.sv
module atten_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) stage[s] <= '0;
        else       stage[s] <= asyncIn;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (!rstN) stage[s] <= '0;
        else       stage[s] <= stage[s-1];
      end
    end
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/atten_ctrl.sv
module atten_ctrl
  import atten_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     modeSerial,
  input  logic     serClkS,
  input  logic     latchS,
  output ctrlStb_t stb
);

  logic serClkPrev;
  logic latchPrev;
  logic serRise;
  logic latchRise;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      serClkPrev <= 1'b0;
      latchPrev  <= 1'b0;
    end else begin
      serClkPrev <= serClkS;
      latchPrev  <= latchS;
    end
  end

  assign serRise   = serClkS & ~serClkPrev;
  assign latchRise = latchS & ~latchPrev;

  always_comb begin
    stb = '0;
    if (modeSerial) begin
      stb.shiftEn   = serRise & ~latchS;   // clock inhibit while latch high
      stb.loadShift = latchRise;
    end else begin
      // latch high: direct follow; first high cycle is the latched capture
      stb.loadPar = latchS;
    end
  end

endmodule

// File: rtl/atten_datapath.sv
module atten_datapath
  import atten_pkg::*;
#(
  parameter int WIDTH = ATTEN_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStb_t         stb,
  input  logic             serDataS,
  input  logic [WIDTH-1:0] parWord,
  output logic [WIDTH-1:0] attenWord,
  output logic             updateStb
);

  logic [WIDTH-1:0] shiftReg;
  logic [WIDTH-1:0] nextWord;

  always_comb begin
    if (stb.loadShift)    nextWord = shiftReg;
    else if (stb.loadPar) nextWord = parWord;
    else                  nextWord = attenWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg  <= parWord;
      attenWord <= parWord;
      updateStb <= 1'b0;
    end else begin
      if (stb.shiftEn) shiftReg <= {shiftReg[WIDTH-2:0], serDataS};
      attenWord <= nextWord;
      updateStb <= (nextWord != attenWord);
    end
  end

endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl
  import atten_pkg::*;
#(
  parameter int WIDTH       = ATTEN_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeSerial,
  input  logic             serClk,
  input  logic             serData,
  input  logic             latchEn,
  input  logic [WIDTH-1:0] parWord,
  output logic [WIDTH-1:0] attenWord,
  output logic             updateStb
);

  localparam int BUS_W = 3;

  logic [BUS_W-1:0] busSync;
  logic             serClkSync;
  logic             serDataSync;
  logic             latchSync;
  ctrlStb_t         ctrlStb;

  atten_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({latchEn, serData, serClk}),
    .syncOut (busSync)
  );

  assign serClkSync  = busSync[0];
  assign serDataSync = busSync[1];
  assign latchSync   = busSync[2];

  atten_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .modeSerial (modeSerial),
    .serClkS    (serClkSync),
    .latchS     (latchSync),
    .stb        (ctrlStb)
  );

  atten_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (ctrlStb),
    .serDataS  (serDataSync),
    .parWord   (parWord),
    .attenWord (attenWord),
    .updateStb (updateStb)
  );

endmodule

// File: rtl/step_atten_ctrl_chk.sv
module step_atten_ctrl_chk #(
  parameter int WIDTH = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             modeSerial,
  input logic             latchSync,
  input logic [WIDTH-1:0] parWord,
  input logic [WIDTH-1:0] attenWord,
  input logic             updateStb
);

  // R10
  strobe_on_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && attenWord != $past(attenWord)) |-> updateStb);

  // R10
  strobe_only_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    updateStb |-> attenWord != $past(attenWord));

  // R6
  direct_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(modeSerial) && $past(latchSync)) |-> attenWord == $past(parWord));

  // R5 R7
  hold_without_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(latchSync)) |-> $stable(attenWord));

  // R8
  reset_default_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (attenWord == $past(parWord) && !updateStb));

endmodule

bind step_atten_ctrl step_atten_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .modeSerial (modeSerial),
  .latchSync  (latchSync),
  .parWord    (parWord),
  .attenWord  (attenWord),
  .updateStb  (updateStb)
);

// File: tb/sim_step_atten_ctrl.sv
`timescale 1ns/1ps
module sim_step_atten_ctrl;

  logic       clk = 1'b0;
  logic       rstN;
  logic       modeSerial;
  logic       serClk;
  logic       serData;
  logic       latchEn;
  logic [5:0] parWord;
  logic [5:0] attenWord;
  logic       updateStb;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [5:0] curWord;

  always #4 clk = ~clk;  // 125 MHz

  step_atten_ctrl u0 (
    .clk(clk), .rstN(rstN), .modeSerial(modeSerial), .serClk(serClk),
    .serData(serData), .latchEn(latchEn), .parWord(parWord),
    .attenWord(attenWord), .updateStb(updateStb)
  );

  // serial words, each equal to the attenuation in half-dB units (R1)
  localparam logic [5:0] VEC [8] = '{6'd63, 6'd0, 6'd31, 6'd32, 6'd32, 6'd21, 6'd42, 6'd1};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setLatch(input logic v);
    latchEn = v;
    waitN(4);
  endtask

  task automatic sendBits(input logic [15:0] bits, input int n);
    for (int i = 0; i < n; i++) begin
      serData = bits[n-1-i];
      serClk  = 1'b0;
      waitN(3);
      serClk = 1'b1;
      waitN(3);
      serClk = 1'b0;
      waitN(3);
    end
  endtask

  // latch enable assumed low and settled; checks exact timing (R11)
  task automatic latchRise(input logic [5:0] expWord, input string req);
    logic expStb;
    expStb = (expWord != curWord);
    latchEn = 1'b1;
    waitN(2);
    chk({req, " R11 word before third edge"}, attenWord, curWord);
    waitN(1);
    chk({req, " word"}, attenWord, expWord);
    chk({req, " R10 strobe"}, updateStb, expStb);
    waitN(1);
    chk({req, " R10 strobe width"}, updateStb, 0);
    curWord = expWord;
  endtask

  initial begin
    rstN = 1'b0; modeSerial = 1'b1; serClk = 1'b0; serData = 1'b0;
    latchEn = 1'b1; parWord = 6'd45;
    waitN(4);
    rstN = 1'b1;
    waitN(1);
    chk("R8 reset word serial mode", attenWord, 45);
    chk("R8 reset strobe", updateStb, 0);
    waitN(4);
    chk("R8 shift register default", attenWord, 45);
    curWord = 6'd45;
    setLatch(1'b0);

    // table walk: serial loads
    foreach (VEC[k]) begin
      sendBits({10'd0, VEC[k]}, 6);
      chk("R5 word held before latch", attenWord, curWord);
      latchRise(VEC[k], "R1 R3 R5");
      setLatch(1'b0);
    end

    // fewer than six clocks
    sendBits(16'b10, 2);
    latchRise({curWord[3:0], 2'b10}, "R9 short");
    setLatch(1'b0);
    // more than six clocks
    sendBits(16'hA7, 8);
    latchRise(6'd39, "R9 long");

    // clock inhibit with latch high
    sendBits(16'h0, 6);
    setLatch(1'b0);
    latchRise(6'd39, "R4 inhibit");
    setLatch(1'b0);

    // latched parallel
    modeSerial = 1'b0;
    waitN(4);
    chk("R2 mode switch no load", attenWord, 39);
    parWord = 6'd12; waitN(4);
    chk("R7 pins ignored", attenWord, 39);
    parWord = 6'd50; waitN(4);
    chk("R7 pins ignored", attenWord, 39);
    sendBits(16'h3F, 6);
    chk("R2 serial ignored in parallel", attenWord, 39);
    latchRise(6'd50, "R7 capture");

    // direct parallel
    parWord = 6'd9; waitN(1);
    chk("R6 follow", attenWord, 9);
    chk("R10 follow strobe", updateStb, 1);
    parWord = 6'd9; waitN(1);
    chk("R10 no change strobe", updateStb, 0);
    parWord = 6'd60; waitN(1);
    chk("R6 follow", attenWord, 60);
    curWord = 6'd60;

    // back to serial: shift register untouched by parallel activity
    modeSerial = 1'b1;
    setLatch(1'b0);
    latchRise(6'd39, "R2 serial restore");

    // reset in latched-parallel mode
    modeSerial = 1'b0;
    setLatch(1'b0);
    parWord = 6'd19;
    rstN = 1'b0;
    waitN(2);
    rstN = 1'b1;
    waitN(1);
    chk("R8 reset word parallel mode", attenWord, 19);
    chk("R8 reset strobe", updateStb, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule